// File: doc/BRIEF.md
# I2C Slave Byte Engine with Address-Match Interrupt

This block handles the byte level of an I2C slave. SCL and SDA are sampled on a prescaled tick and pass through a two-stage synchronizer. From those samples the block detects start and stop conditions and the rising and falling clock edges. A single 8-bit shift register carries both directions. It shifts data in on every SCL rise. In transmit it feeds the SDA output latch, which is updated on SCL falls. The first byte after a start is treated as an address. Its upper seven bits are compared with a programmable local address. Reserved extension codes are flagged instead of being compared.

A host reaches the block through a small byte-wide register port: shift data, own address, control and status. It gets one interrupt request, a single-cycle pulse. The interrupt point is selectable per byte, either after the 8th or after the 9th SCL falling edge. A stop condition can also raise the interrupt. SDA is open-drain: the `sda_oe` output pulls the line low whenever the output latch holds 0. SCL is an input only.

Top module: `i2c_slave_core`

## Requirements
- R1: After reset the data, own-address, control and status registers all read 0x00, `irq` is low and `sda_oe` is low.
- R2: Register offsets are: data = 0, own address = 1, control = 2, status = 3. The own-address and control registers read back the full byte last written. Control bits are: bit0 enable, bit1 interrupt point, bit2 stop interrupt enable.
- R3: When the first byte after a start is not an extension code and its bits [7:1] equal own-address bits [7:1], several things happen. Status bit0 is set, the slave pulls SDA low during the 9th clock, and an interrupt pulse is issued.
- R4: When the address byte neither matches nor is an extension code, the slave does not acknowledge and raises no interrupt. It also leaves all following bytes unacknowledged and interrupt-free until the next start.
- R5: An address byte whose bits [7:4] are 0000 or 1111 sets status bit1 and raises an interrupt. It is never acknowledged, and it leaves status bit0 clear even when it equals the own address.
- R6: With control bit1 clear, the interrupt pulse follows the falling edge of the 8th SCL clock of a byte. With control bit1 set, it follows the 9th. The pulse lasts one system clock cycle.
- R7: After a matched address with R/W bit 0, each data byte is acknowledged, becomes readable at the data offset, and raises one interrupt.
- R8: After a matched address with R/W bit 1, the data register is shifted out MSB first on SDA. While transmitting, status bit3 reads 1. A master NACK on the 9th clock releases SDA and ends the transfer.
- R9: A stop condition sets status bit2 and returns the engine to idle. It raises an interrupt only when control bit2 is set.
- R10: A read of the status offset returns the current flags and then clears status bits [2:0].
- R11: With control bit0 clear, bus activity is ignored: no acknowledge, no interrupt and no status change.
- R12: A repeated start restarts the bit count and treats the next byte as a new address, even after ignored bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on offset 3) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest situation to reach from the ports is the transmit turnaround. The host has to reload the shared shift register after the 9th SCL fall of the address byte and before the first rise of the data byte. Otherwise the address just received is sent back. The bench selects the 9th-clock interrupt point and places a register write in that short low phase. It then reads the byte back through a master-side receive and finishes with a NACK. A second hard case is a repeated start that follows ignored bytes: the stimulus sends a foreign address, then data, then a new start with the own address.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX,
    ST_IGN
  } eng_st_t;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_OWN  = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;
endpackage

// File: rtl/i2cs_sampler.sv
module i2cs_sampler #(
  parameter int PRESC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev,
  output logic sda_lvl
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PW-1:0] pcnt, pcnt_n;
  logic          tick, tick_d;
  logic [1:0]    s1, s2, s3;   // {scl, sda}

  always_comb begin
    tick   = (pcnt == PW'(PRESC - 1));
    pcnt_n = tick ? '0 : pcnt + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      tick_d <= 1'b0;
      s1     <= 2'b11;
      s2     <= 2'b11;
      s3     <= 2'b11;
    end else begin
      pcnt   <= pcnt_n;
      tick_d <= tick;
      if (tick) begin
        s1 <= {scl_i, sda_i};
        s2 <= s1;
        s3 <= s2;
      end
    end
  end

  always_comb begin
    scl_rise = tick_d &  s2[1] & ~s3[1];
    scl_fall = tick_d & ~s2[1] &  s3[1];
    start_ev = tick_d &  s2[1] &  s3[1] & ~s2[0] &  s3[0];
    stop_ev  = tick_d &  s2[1] &  s3[1] &  s2[0] & ~s3[0];
    sda_lvl  = s2[0];
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wtim,
  input  logic [BYTE_W-1:1] own_adr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_lvl,
  input  logic              sh_wr,
  input  logic [BYTE_W-1:0] sh_wdata,
  output logic [BYTE_W-1:0] sh_q,
  output logic              sda_oe,
  output logic              in_tx,
  output logic              ev_hit,
  output logic              ev_ext,
  output logic              ev_stop,
  output logic              ev_irq
);
  localparam logic [CNT_W-1:0] N8 = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] N9 = CNT_W'(BYTE_W + 1);

  eng_st_t           st, st_n;
  logic [CNT_W-1:0]  rcnt, rcnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              so, so_n;      // SDA output latch, 1 = released
  logic              hit, hit_n, ext, ext_n, rwb, rwb_n, mack, mack_n;
  logic              act, ext_now, hit_now, live;

  always_comb begin
    st_n = st; rcnt_n = rcnt; sh_n = sh; so_n = so;
    hit_n = hit; ext_n = ext; rwb_n = rwb; mack_n = mack;
    ev_hit = 1'b0; ev_ext = 1'b0; ev_stop = 1'b0; ev_irq = 1'b0;
    act = 1'b0; ext_now = 1'b0; hit_now = 1'b0;
    live = (st != ST_IDLE) && (st != ST_IGN);
    if (!en) begin
      st_n = ST_IDLE; rcnt_n = '0; so_n = 1'b1;
    end else if (stop_ev) begin
      st_n = ST_IDLE; rcnt_n = '0; so_n = 1'b1; ev_stop = 1'b1;
    end else if (start_ev) begin
      st_n = ST_ADDR; rcnt_n = '0; so_n = 1'b1; hit_n = 1'b0; ext_n = 1'b0;
    end else if (scl_rise && live) begin
      if (rcnt < N8) sh_n = {sh[BYTE_W-2:0], sda_lvl};
      else           mack_n = ~sda_lvl;
      rcnt_n = rcnt + CNT_W'(1);
    end else if (scl_fall && live) begin
      if (rcnt == N8) begin
        if (st == ST_ADDR) begin
          ext_now = (sh[7:4] == 4'h0) || (sh[7:4] == 4'hF);
          hit_now = !ext_now && (sh[BYTE_W-1:1] == own_adr);
          hit_n = hit_now; ext_n = ext_now; rwb_n = sh[0];
          ev_hit = hit_now; ev_ext = ext_now;
          so_n = ~hit_now;
          act = hit_now | ext_now;
        end else begin
          so_n = (st != ST_RX);
          act = 1'b1;
        end
        ev_irq = act & ~wtim;
      end else if (rcnt == N9) begin
        rcnt_n = '0;
        so_n = 1'b1;
        if (st == ST_ADDR) begin
          act = hit | ext;
          if (hit && rwb)  begin st_n = ST_TX; so_n = sh[BYTE_W-1]; end
          else if (hit)    st_n = ST_RX;
          else             st_n = ST_IGN;
        end else if (st == ST_TX) begin
          act = 1'b1;
          if (mack) so_n = sh[BYTE_W-1];
          else      st_n = ST_IGN;
        end else begin
          act = 1'b1;
        end
        ev_irq = act & wtim;
      end else if (st == ST_TX && rcnt != '0) begin
        so_n = sh[BYTE_W-1];
      end
    end
    if (sh_wr) begin
      sh_n = sh_wdata;
      if (st == ST_TX && rcnt == '0 && en) so_n = sh_wdata[BYTE_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rcnt <= '0; sh <= '0; so <= 1'b1;
      hit <= 1'b0; ext <= 1'b0; rwb <= 1'b0; mack <= 1'b0;
    end else begin
      st <= st_n; rcnt <= rcnt_n; sh <= sh_n; so <= so_n;
      hit <= hit_n; ext <= ext_n; rwb <= rwb_n; mack <= mack_n;
    end
  end

  assign sh_q   = sh;
  assign sda_oe = ~so;
  assign in_tx  = (st == ST_TX);

  // R12
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && start_ev && !stop_ev) |=> (st == ST_ADDR && rcnt == '0));
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_ev) |=> (st == ST_IDLE && so));
  // R7
  ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX && !so) |-> (rcnt >= N8));
  // R11
  disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (so && st == ST_IDLE));
  // R6
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= N9);
endmodule

// File: rtl/i2c_slave_core.sv
module i2c_slave_core
  import i2cs_pkg::*;
#(
  parameter int PRESC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [1:0] rst_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_ni = rst_q[1];

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_lvl;
  logic [BYTE_W-1:0] own_q, own_n, ctrl_q, ctrl_n, sh_q;
  logic [2:0] stat_q, stat_n;
  logic       irq_n, in_tx, ev_hit, ev_ext, ev_stop, ev_irq, sh_wr;

  i2cs_sampler #(.PRESC(PRESC)) u_samp (
    .clk(clk), .rst_n(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_lvl(sda_lvl)
  );

  assign sh_wr = reg_wr && (reg_addr == RA_DATA);

  i2cs_engine u_eng (
    .clk(clk), .rst_n(rst_ni), .en(ctrl_q[0]), .wtim(ctrl_q[1]),
    .own_adr(own_q[BYTE_W-1:1]), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .sda_lvl(sda_lvl),
    .sh_wr(sh_wr), .sh_wdata(reg_wdata), .sh_q(sh_q), .sda_oe(sda_oe),
    .in_tx(in_tx), .ev_hit(ev_hit), .ev_ext(ev_ext), .ev_stop(ev_stop),
    .ev_irq(ev_irq)
  );

  always_comb begin
    own_n  = (reg_wr && reg_addr == RA_OWN)  ? reg_wdata : own_q;
    ctrl_n = (reg_wr && reg_addr == RA_CTRL) ? reg_wdata : ctrl_q;
    stat_n = (reg_rd && reg_addr == RA_STAT) ? 3'b000 : stat_q;
    if (ev_hit)  stat_n[0] = 1'b1;
    if (ev_ext)  stat_n[1] = 1'b1;
    if (ev_stop) stat_n[2] = 1'b1;
    irq_n = ev_irq | (ev_stop & ctrl_q[2]);
    unique case (reg_addr)
      RA_DATA: reg_rdata = sh_q;
      RA_OWN:  reg_rdata = own_q;
      RA_CTRL: reg_rdata = ctrl_q;
      default: reg_rdata = {4'b0000, in_tx, stat_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= '0; ctrl_q <= '0; stat_q <= '0; irq <= 1'b0;
    end else begin
      own_q <= own_n; ctrl_q <= ctrl_n; stat_q <= stat_n; irq <= irq_n;
    end
  end

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |=> !irq);
  // R10
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (reg_rd && reg_addr == RA_STAT && !ev_hit && !ev_ext && !ev_stop)
      |=> (stat_q == 3'b000));
  // R9
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_stop |=> stat_q[2]);
  // R11
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl_q[0] && $past(!ctrl_q[0])) |-> !irq_n);
endmodule

// File: tb/i2c_slave_core_bench.sv
module i2c_slave_core_bench;
  localparam int H = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic sda_oe, irq, sda_line;

  int n_chk = 0, n_bad = 0, irq_cnt = 0, irq_at = 0, clk_no = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_slave_core u_i2c_slave_core (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) if (irq === 1'b1) begin irq_cnt++; irq_at = clk_no; end

  function automatic bit is_ext(input logic [7:0] b);
    return (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
  endfunction
  function automatic bit exp_hit(input logic [7:0] b, input logic [7:0] own);
    return !is_ext(b) && (b[7:1] == own[7:1]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(H); scl_m = 1'b1; wclk(H);
    sda_m = 1'b0; wclk(H); scl_m = 1'b0; clk_no = 0;
  endtask
  task automatic bus_stop();
    wclk(H/2); sda_m = 1'b0; wclk(H/2); scl_m = 1'b1; wclk(H);
    sda_m = 1'b1; wclk(H);
  endtask
  task automatic bit_io(input logic b, output logic r);
    wclk(H/2); sda_m = b; wclk(H/2); scl_m = 1'b1;
    clk_no = (clk_no == 9) ? 1 : clk_no + 1;
    wclk(H/2); r = sda_line; wclk(H/2); scl_m = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(b[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
    bit_io(~mack, r);
  endtask

  initial begin
    wclk(190000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!done) begin
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, own, ab, db;
    logic ack;
    int nb, m, wt, se, exp_irq;
    void'($urandom(32'h5EED));
    wclk(5); rst_n = 1'b1; wclk(4);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin reg_read(2'(a), d); chk("R1 reg", d, 0); end
    chk("R1 irq", irq, 0); chk("R1 sda_oe", sda_oe, 0);

    // R2 readback
    reg_write(2'd1, 8'h5A); reg_read(2'd1, d); chk("R2 own", d, 8'h5A);
    reg_write(2'd2, 8'hE6); reg_read(2'd2, d); chk("R2 ctrl", d, 8'hE6);

    // R3 R7 match, 8th-clock interrupt, receive data
    reg_write(2'd1, 8'hA4); reg_write(2'd2, 8'h01); irq_cnt = 0;
    bus_start(); send_byte(8'hA4, ack);
    chk("R3 ack", ack, 1); chk("R3 irq", irq_cnt, 1); chk("R6 at8", irq_at, 8);
    send_byte(8'h3C, ack);
    chk("R7 ack", ack, 1); reg_read(2'd0, d); chk("R7 data", d, 8'h3C);
    chk("R7 irq", irq_cnt, 2);
    bus_stop(); wclk(H);
    chk("R9 no stop irq", irq_cnt, 2);
    reg_read(2'd3, d); chk("R10 status", d, 8'h05);
    reg_read(2'd3, d); chk("R10 cleared", d, 8'h00);

    // R6 9th-clock point, R9 stop interrupt
    reg_write(2'd2, 8'h07); irq_cnt = 0;
    bus_start(); send_byte(8'hA4, ack);
    wclk(20); chk("R6 at9", irq_at, 9); chk("R6 count", irq_cnt, 1);
    bus_stop(); wclk(H);
    chk("R9 stop irq", irq_cnt, 2);
    reg_read(2'd3, d);

    // R4 mismatch, R12 repeated start
    reg_write(2'd2, 8'h01); irq_cnt = 0;
    bus_start(); send_byte(8'hB2, ack); chk("R4 nack addr", ack, 0);
    send_byte(8'hA4, ack); chk("R4 ignored data", ack, 0);
    chk("R4 irq", irq_cnt, 0);
    bus_start(); send_byte(8'hA4, ack);
    chk("R12 ack", ack, 1); chk("R12 irq", irq_cnt, 1);
    bus_stop(); wclk(H);
    reg_read(2'd3, d); chk("R12 status", d, 8'h05);

    // R5 extension codes
    reg_write(2'd1, 8'h00); irq_cnt = 0;
    bus_start(); send_byte(8'h00, ack);
    chk("R5 nack", ack, 0); chk("R5 irq", irq_cnt, 1);
    reg_read(2'd3, d); chk("R5 status", d, 8'h02);
    bus_start(); send_byte(8'hF6, ack);
    chk("R5 F nack", ack, 0); chk("R5 F irq", irq_cnt, 2);
    bus_stop(); wclk(H); reg_read(2'd3, d);

    // R11 disabled
    reg_write(2'd1, 8'hA4); reg_write(2'd2, 8'h00); irq_cnt = 0;
    bus_start(); send_byte(8'hA4, ack); chk("R11 nack", ack, 0);
    bus_stop(); wclk(H);
    chk("R11 irq", irq_cnt, 0);
    reg_read(2'd3, d); chk("R11 status", d, 8'h00);

    // R8 transmit
    reg_write(2'd2, 8'h03); irq_cnt = 0;
    bus_start(); send_byte(8'hA5, ack); chk("R8 addr ack", ack, 1);
    wclk(18); reg_write(2'd0, 8'h96);
    recv_byte(1'b1, d); chk("R8 byte0", d, 8'h96);
    wclk(18); reg_write(2'd0, 8'h3B);
    reg_read(2'd3, d); chk("R8 tx flag", d, 8'h09);
    recv_byte(1'b0, d); chk("R8 byte1", d, 8'h3B);
    wclk(30); chk("R8 released", sda_oe, 0);
    reg_read(2'd3, d); chk("R8 tx end", d, 8'h00);
    chk("R8 irq", irq_cnt, 3);
    bus_stop(); wclk(H); reg_read(2'd3, d);

    // random receive transactions
    for (int it = 0; it < 16; it++) begin
      own = {4'(1 + $urandom % 14), 4'($urandom)};
      wt = $urandom % 2; se = $urandom % 2; m = $urandom % 2;
      if (m != 0) ab = {own[7:1], 1'b0};
      else begin
        ab = 8'($urandom) & 8'hFE;
        while (is_ext(ab) || ab[7:1] == own[7:1]) ab = 8'($urandom) & 8'hFE;
      end
      nb = 1 + $urandom % 3;
      reg_write(2'd1, own); reg_write(2'd2, {5'b0, 1'(se), 1'(wt), 1'b1});
      irq_cnt = 0;
      bus_start(); send_byte(ab, ack);
      chk("R3 rnd ack", ack, int'(exp_hit(ab, own)));
      wclk(20);
      if (m != 0) chk("R6 rnd point", irq_at, (wt != 0) ? 9 : 8);
      for (int k = 0; k < nb; k++) begin
        db = 8'($urandom);
        send_byte(db, ack);
        chk("R7 rnd ack", ack, m);
        if (m != 0) begin reg_read(2'd0, d); chk("R7 rnd data", d, db); end
      end
      bus_stop(); wclk(H);
      exp_irq = ((m != 0) ? 1 + nb : 0) + se;
      chk("R9 rnd irq", irq_cnt, exp_irq);
      reg_read(2'd3, d); chk("R4 rnd status", d, {5'b0, 1'b1, 1'b0, 1'(m)});
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule